// File: doc/BRIEF.md
# Bernoulli Error-Pattern Generator

This block builds a wide error pattern in which every bit is set on its own with a programmable probability. Each pattern bit costs one clock cycle: a 32-bit pseudo-random word from an internal linear-feedback shift register is compared against a threshold. The threshold is the probability already scaled to the 32-bit range. The result of the comparison is shifted into the pattern register. A full pattern of 1024 bits therefore takes 1024 generation cycles. A one-cycle valid pulse marks its completion, and the pattern then stays put until the next start.

A seed port puts the generator into a known state, so the same seed and threshold give a repeatable pattern. An all-zero seed cannot run a shift-register generator, so it is replaced by a fixed constant. A host loads a seed, presents a threshold, and pulses start. The threshold is captured on that start edge, and the host waits for the valid pulse. Patterns started back to back without reseeding continue the same pseudo-random stream.

Control is a three-state machine. `ST_IDLE` is the state after reset. `ST_RUN` produces one bit per cycle. `ST_DONE` lasts a single cycle and drives the valid pulse. The transitions are:
- IDLE→RUN on an accepted start.
- RUN→RUN while bits remain.
- RUN→DONE after the last bit.
- DONE→RUN on a start in that cycle.
- DONE→IDLE otherwise.

Top module: `bernoulli_pattern_gen`

## Requirements
- R1: After reset, `pattern` is all zeros, `pattern_valid` is 0, and the controller is idle. The generator state after reset is the fallback constant 32'h5EED_0001.
- R2: When `seed_load` is high at a rising edge, the generator state becomes `seed_val`. If `seed_val` is zero, the state becomes 32'h5EED_0001 instead.
- R3: The generator is a right-shifting Galois register whose next state is `{1'b0, s[31:1]} ^ (s[0] ? 32'h80200003 : 0)`. It never holds zero. It advances exactly once per generation cycle and holds in every other cycle unless a seed is loaded.
- R4: A pattern bit is 1 exactly when the current generator word, read as unsigned, is strictly less than the captured threshold.
- R5: Draw k of a run (k = 0 first) lands in `pattern[k]`. Draw 0 uses the generator state present on the start edge. A run makes 1024 draws.
- R6: The threshold is captured on the edge that accepts start. Changes to `threshold` during the run have no effect on the pattern.
- R7: Call the edge that accepts start E0. `pattern_valid` is high from edge E1024 to edge E1025 and low in every other cycle of the run. It never stays high for two cycles.
- R8: A start strobe that arrives while a run is in progress is ignored. The run's timing, threshold and pattern are unchanged.
- R9: Outside a run, `pattern` holds its value. A later run continues the pseudo-random stream from where the previous one stopped.
- R10: A threshold of 0 gives an all-zero pattern. A threshold of 32'hFFFFFFFF gives all ones, except at draws whose word equals 32'hFFFFFFFF.
- R11: An accepted start clears the bit counter, so every run takes the full 1024 generation cycles, including a run that follows another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| seed_load | input | 1 | Load `seed_val` into the generator at this edge |
| seed_val | input | 32 | Seed value; zero is replaced by the fallback constant |
| threshold | input | 32 | Probability scaled to 0..2^32-1; captured at start |
| start | input | 1 | Begin a new pattern when not already running |
| pattern | output | 1024 | Error pattern, bit k from draw k |
| pattern_valid | output | 1 | One-cycle pulse when the pattern is complete |

## Verification
Several properties are checked every cycle by assertions:
- the generator word is never zero, and it stays frozen outside a run;
- the captured threshold and the pattern are stable whenever they should be;
- an accepted start clears the counter, and a start during a run leaves the machine running;
- the valid pulse follows the last count and lasts exactly one cycle;
- a zero threshold inserts only zeros.

Only the bench scenarios can show that whole patterns match an arithmetic model of the generator and comparator, across these cases:
- several thresholds, including both extremes;
- a zero seed;
- a continued stream across runs;
- a threshold changed or a start pulsed in the middle of a run.

// File: rtl/bpg_pkg.sv
package bpg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } bpg_state_e;

    // Right-shifting Galois step with a given feedback mask
    function automatic logic [31:0] galois_step(input logic [31:0] s,
                                                input logic [31:0] mask);
        logic [31:0] shifted;
        shifted = {1'b0, s[31:1]};
        return s[0] ? (shifted ^ mask) : shifted;
    endfunction

endpackage

// File: rtl/bpg_lfsr.sv
module bpg_lfsr #(
    parameter int          WORD_W   = 32,
    parameter logic [31:0] TAPS     = 32'h8020_0003,
    parameter logic [31:0] FALLBACK = 32'h5EED_0001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] seed,
    input  logic              adv,
    output logic [WORD_W-1:0] word
);

    logic [WORD_W-1:0] state_q;
    logic [WORD_W-1:0] state_nx;
    logic [WORD_W-1:0] seed_fix;

    always_comb begin
        seed_fix = (seed == '0) ? FALLBACK[WORD_W-1:0] : seed;
        state_nx = bpg_pkg::galois_step(state_q, TAPS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FALLBACK[WORD_W-1:0];
        end else if (load) begin
            state_q <= seed_fix;
        end else if (adv) begin
            state_q <= state_nx;
        end
    end

    assign word = state_q;

endmodule

// File: rtl/bpg_ctrl.sv
module bpg_ctrl #(
    parameter int PAT_W = 1024,
    localparam int CNT_W = $clog2(PAT_W)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    output bpg_pkg::bpg_state_e  state_o,
    output logic [CNT_W-1:0]     cnt_o,
    output logic                 capture,
    output logic                 shift_en,
    output logic                 done
);
    import bpg_pkg::*;

    localparam logic [CNT_W-1:0] LAST = CNT_W'(PAT_W - 1);

    bpg_state_e       state_q;
    bpg_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             accept;

    assign accept = start && (state_q != ST_RUN);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_RUN;
            ST_RUN:  if (cnt_q == LAST) state_d = ST_DONE;
            ST_DONE: state_d = accept ? ST_RUN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and bit counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cnt_q <= '0;
            end else if (state_q == ST_RUN) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        capture  = accept;
        shift_en = (state_q == ST_RUN);
        done     = (state_q == ST_DONE);
        state_o  = state_q;
        cnt_o    = cnt_q;
    end

endmodule

// File: rtl/bpg_shreg.sv
module bpg_shreg #(
    parameter int PAT_W  = 1024,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [WORD_W-1:0] thr_in,
    input  logic              shift_en,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] thr_o,
    output logic [PAT_W-1:0]  pattern
);

    logic [WORD_W-1:0] thr_q;
    logic [PAT_W-1:0]  pat_q;
    logic              hit;

    assign hit = (word < thr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= '0;
        end else if (capture) begin
            thr_q <= thr_in;
        end
    end

    // new bit enters at the top; after PAT_W shifts draw 0 sits at bit 0
    always_ff @(posedge clk) begin
        if (rst) begin
            pat_q <= '0;
        end else if (shift_en) begin
            pat_q <= {hit, pat_q[PAT_W-1:1]};
        end
    end

    assign thr_o   = thr_q;
    assign pattern = pat_q;

endmodule

// File: rtl/bernoulli_pattern_gen.sv
module bernoulli_pattern_gen #(
    parameter int          PAT_W    = 1024,
    parameter int          WORD_W   = 32,
    parameter logic [31:0] TAPS     = 32'h8020_0003,
    parameter logic [31:0] FALLBACK = 32'h5EED_0001,
    localparam int CNT_W = $clog2(PAT_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seed_load,
    input  logic [WORD_W-1:0] seed_val,
    input  logic [WORD_W-1:0] threshold,
    input  logic              start,
    output logic [PAT_W-1:0]  pattern,
    output logic              pattern_valid
);

    bpg_pkg::bpg_state_e state_w;
    logic [CNT_W-1:0]    cnt_w;
    logic                capture_w;
    logic                shift_w;
    logic [WORD_W-1:0]   word_w;
    logic [WORD_W-1:0]   thr_w;

    bpg_ctrl #(.PAT_W(PAT_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .state_o  (state_w),
        .cnt_o    (cnt_w),
        .capture  (capture_w),
        .shift_en (shift_w),
        .done     (pattern_valid)
    );

    bpg_lfsr #(.WORD_W(WORD_W), .TAPS(TAPS), .FALLBACK(FALLBACK)) u_lfsr (
        .clk  (clk),
        .rst  (rst),
        .load (seed_load),
        .seed (seed_val),
        .adv  (shift_w),
        .word (word_w)
    );

    bpg_shreg #(.PAT_W(PAT_W), .WORD_W(WORD_W)) u_shreg (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture_w),
        .thr_in   (threshold),
        .shift_en (shift_w),
        .word     (word_w),
        .thr_o    (thr_w),
        .pattern  (pattern)
    );

endmodule

// File: rtl/bpg_checker.sv
module bpg_checker #(
    parameter int          PAT_W    = 1024,
    parameter int          WORD_W   = 32,
    parameter logic [31:0] FALLBACK = 32'h5EED_0001,
    localparam int CNT_W = $clog2(PAT_W)
) (
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic                seed_load,
    input logic [WORD_W-1:0]   seed_val,
    input bpg_pkg::bpg_state_e state_q,
    input logic [CNT_W-1:0]    cnt_q,
    input logic [WORD_W-1:0]   thr_q,
    input logic [WORD_W-1:0]   word,
    input logic [PAT_W-1:0]    pattern,
    input logic                pattern_valid
);
    import bpg_pkg::*;

    localparam logic [CNT_W-1:0] LAST = CNT_W'(PAT_W - 1);

    AST_SEED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (seed_load && seed_val == '0) |=> (word == FALLBACK[WORD_W-1:0])); // R2

    AST_WORD_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (word != '0)); // R3

    AST_WORD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_RUN && !seed_load) |=> $stable(word)); // R3

    AST_THR_HELD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |=> $stable(thr_q)); // R6

    AST_VALID_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && cnt_q == LAST) |=> pattern_valid); // R7

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pattern_valid |=> !pattern_valid); // R7

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (start && state_q == ST_RUN && cnt_q != LAST) |=> (state_q == ST_RUN)); // R8

    AST_PATTERN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_RUN) |=> $stable(pattern)); // R9

    AST_ZERO_THR: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && thr_q == '0) |=> !pattern[PAT_W-1]); // R10

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (start && state_q != ST_RUN) |=> (cnt_q == '0 && state_q == ST_RUN)); // R11

endmodule

bind bernoulli_pattern_gen bpg_checker #(
    .PAT_W(PAT_W), .WORD_W(WORD_W), .FALLBACK(FALLBACK)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .seed_load     (seed_load),
    .seed_val      (seed_val),
    .state_q       (state_w),
    .cnt_q         (cnt_w),
    .thr_q         (thr_w),
    .word          (word_w),
    .pattern       (pattern),
    .pattern_valid (pattern_valid)
);

// File: tb/sim_bernoulli_pattern_gen.sv
module sim_bernoulli_pattern_gen;

    localparam int          PW       = 1024;
    localparam logic [31:0] MASK     = 32'h8020_0003;
    localparam logic [31:0] FALLBACK = 32'h5EED_0001;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          seed_load = 1'b0;
    logic [31:0]   seed_val = '0;
    logic [31:0]   threshold = '0;
    logic          start = 1'b0;
    logic [PW-1:0] pattern;
    logic          pattern_valid;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    logic [31:0] model_s;

    always #4 clk = ~clk;

    bernoulli_pattern_gen u0 (
        .clk           (clk),
        .rst           (rst),
        .seed_load     (seed_load),
        .seed_val      (seed_val),
        .threshold     (threshold),
        .start         (start),
        .pattern       (pattern),
        .pattern_valid (pattern_valid)
    );

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return {1'b0, s[31:1]} ^ (s[0] ? MASK : 32'h0);
    endfunction

    task automatic chk(input bit ok, input string req,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_seed(input logic [31:0] s);
        @(negedge clk);
        seed_load = 1'b1;
        seed_val  = s;
        @(negedge clk);
        seed_load = 1'b0;
        model_s   = (s == 32'h0) ? FALLBACK : s;
    endtask

    task automatic gen(input logic [31:0] thr, input bit disturb,
                       input string tag, output logic [PW-1:0] got);
        logic [PW-1:0] exp;
        logic [PW-1:0] snap;
        int early;
        for (int k = 0; k < PW; k++) begin
            exp[k]  = (model_s < thr);
            model_s = nxt(model_s);
        end
        @(negedge clk);
        start     = 1'b1;
        threshold = thr;
        @(negedge clk);
        start     = 1'b0;
        threshold = ~thr;              // R6: must not affect this run
        early = 0;
        for (int i = 1; i <= PW; i++) begin
            if (disturb && i == 400) begin
                start     = 1'b1;      // R8: ignored mid-run
                threshold = 32'h0;
            end
            if (disturb && i == 401) start = 1'b0;
            @(negedge clk);
            if (i < PW && pattern_valid) early++;
        end
        chk(early == 0, {tag, " R7 R11 valid early"}, early, 0);
        chk(pattern_valid == 1'b1, {tag, " R7 valid at last edge"}, pattern_valid, 1);
        chk(pattern === exp, {tag, " R4 R5 R6 pattern"},
            $countones(pattern), $countones(exp));
        got  = pattern;
        snap = pattern;
        @(negedge clk);
        chk(pattern_valid == 1'b0, {tag, " R7 valid one cycle"}, pattern_valid, 0);
        repeat (6) @(negedge clk);
        chk(pattern === snap && !pattern_valid, {tag, " R9 pattern holds"},
            $countones(pattern), $countones(snap));
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [PW-1:0] got;
        logic [PW-1:0] all_but0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(pattern == '0, "R1 reset pattern", $countones(pattern), 0);
        chk(pattern_valid == 1'b0, "R1 reset valid", pattern_valid, 0);

        // R1/R3: run straight from reset state uses fallback constant
        model_s = FALLBACK;
        gen(32'h8000_0000, 1'b0, "reset-state half", got);

        do_seed(32'hACE1_ACE1);
        gen(32'h8000_0000, 1'b0, "seeded half", got);
        // R9 R3: idle gap, then stream continues
        repeat (10) @(negedge clk);
        gen(32'h4000_0000, 1'b0, "continued quarter", got);
        gen(32'h2000_0000, 1'b1, "R8 disturbed eighth", got);

        do_seed(32'h0);                // R2 zero seed
        gen(32'hC000_0000, 1'b0, "R2 zero seed", got);

        gen(32'h0, 1'b0, "R10 zero thr", got);
        chk(got == '0, "R10 zero threshold all zeros", $countones(got), 0);

        do_seed(32'hFFFF_FFFF);
        gen(32'hFFFF_FFFF, 1'b0, "R10 full thr", got);
        all_but0 = {{(PW-1){1'b1}}, 1'b0};
        chk(got === all_but0, "R10 full threshold all ones but draw 0",
            $countones(got), PW - 1);

        do_seed(32'h0000_0001);
        gen(32'h0000_0001, 1'b0, "R4 strict compare", got);
        chk(got[0] == 1'b0, "R4 word equal to threshold gives 0", got[0], 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule